// File: doc/BRIEF.md
# Nine-Bit Multidrop Serial Port

This block is a full-duplex asynchronous serial port. Every frame it sends or receives carries a low start bit, a data byte with the least significant bit first, an extra ninth bit, and a high stop bit. Each bit lasts one oversampling period of `OVS` baud ticks. The ticks come from an external rate generator as a one-cycle strobe, `OVS` times per bit.

A write strobe with a byte starts a transmission. The ninth bit is taken from a control input at the moment of the write. The transmitter raises a done flag as the stop bit begins. The receiver synchronises the line, finds a falling edge and confirms the start bit at mid-bit. It decides each bit by a vote of three samples around the bit centre.

At mid-stop the receiver offers the frame to a load gate. The frame is stored and the receive flag raised only if the flag is clear. In multidrop mode the frame must also carry a ninth bit of 1 and a byte that matches the own address or the broadcast address under the mask. Both flags stay set until their clear strobes, and their OR drives an interrupt line.

Top module: `uart9_addr_port`

## Requirements
- R1: A transmitted frame is a 0 start bit, then data bits 0 to 7 in that order, then the ninth bit latched from `tx_bit9` at the write, then a 1 stop bit. Each bit is `OVS` ticks long, and `tx_pin` is 1 when no frame is in progress.
- R2: `tx_done` rises on the clock edge where the stop bit begins. It stays at 1 until `tx_done_clr` is pulsed.
- R3: A `tx_write` that arrives while a frame is being sent is ignored. The frame in flight keeps its bits.
- R4: A received frame stores its eight data bits in `rx_data` (bit 0 received first) and its ninth bit in `rx_bit9`. The value of the stop bit has no effect on acceptance.
- R5: While `rx_enable` is 0, no frame is started and no flag or data changes.
- R6: A frame that completes while `rx_done` is 1 is dropped. `rx_data` and `rx_bit9` keep the earlier frame, and `rx_done_clr` returns `rx_done` to 0.
- R7: With `mp_mode` at 1, a frame is loaded only if its ninth bit is 1 and, for every bit i where `addr_mask[i]` is 1, byte bit i equals `own_addr[i]` (own match) or byte bit i equals `bcast_addr[i]` (broadcast match).
- R8: A frame rejected by the load gate leaves `rx_data`, `rx_bit9` and `rx_done` unchanged.
- R9: A low pulse on `rx_pin` that is back high by the centre of the start bit is treated as a false start, and the receiver returns to idle ready for the next frame.
- R10: A one-sample glitch at the centre of a data bit does not change the received value.
- R11: `irq` is 1 exactly when `tx_done` or `rx_done` is 1.
- R12: After reset `tx_pin` is 1, both flags and `irq` are 0, and `rx_data` and `rx_bit9` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | Oversampling strobe, OVS per bit |
| tx_data | input | DATA_W | Byte to send |
| tx_bit9 | input | 1 | Ninth bit to send |
| tx_write | input | 1 | Starts a transmission when idle |
| tx_done_clr | input | 1 | Clears tx_done |
| tx_pin | output | 1 | Serial output line |
| rx_pin | input | 1 | Serial input line |
| rx_enable | input | 1 | Allows new frames to start |
| mp_mode | input | 1 | Multidrop address filtering on |
| own_addr | input | DATA_W | Own station address |
| addr_mask | input | DATA_W | Bits that take part in matching |
| bcast_addr | input | DATA_W | Broadcast address |
| rx_done_clr | input | 1 | Clears rx_done |
| rx_data | output | DATA_W | Last loaded byte |
| rx_bit9 | output | 1 | Last loaded ninth bit |
| tx_done | output | 1 | Transmit-done flag |
| rx_done | output | 1 | Receive-done flag |
| irq | output | 1 | OR of both flags |

## Verification
The hardest behaviour to reach from the ports is the address gate. Its result depends on all eight bits of the byte, on the ninth bit, and on which bits the mask exposes. The bench therefore enables multidrop mode and sends every one of the 256 byte values with a ninth bit of 1 under a partial mask. It computes the own and broadcast matches arithmetically for each byte. It checks that rejected frames leave the previously loaded byte in place and that each accepted frame replaces it. Matching bytes sent with a ninth bit of 0, a zero mask, an overrun pair, a half-bit false start and centre glitches cover the remaining gate and sampling corners.

// File: rtl/uart9_pkg.sv
package uart9_pkg;

   typedef enum logic [1:0] {
      TX_IDLE  = 2'd0,
      TX_SHIFT = 2'd1,
      TX_STOP  = 2'd2
   } tx_state_e;

   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_START = 2'd1,
      RX_BITS  = 2'd2,
      RX_STOP  = 2'd3
   } rx_state_e;

   function automatic logic vote3(input logic [2:0] s);
      return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
   endfunction

endpackage

// File: rtl/uart9_tx.sv
module uart9_tx
   import uart9_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OVS    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr,
   input  logic [DATA_W-1:0] din,
   input  logic              bit9,
   output logic              line,
   output logic              done_set
);
   localparam int CW      = $clog2(OVS);
   localparam int NSH     = DATA_W + 2;
   localparam int IW      = $clog2(NSH);
   localparam logic [CW-1:0] CNT_LAST = CW'(OVS - 1);
   localparam logic [IW-1:0] IDX_LAST = IW'(NSH - 1);

   tx_state_e        state;
   logic [CW-1:0]    cnt;
   logic [IW-1:0]    idx;
   logic [NSH-1:0]   sh;
   logic             bit_end;

   assign bit_end  = tick && (cnt == CNT_LAST);
   assign done_set = (state == TX_SHIFT) && bit_end && (idx == IDX_LAST);
   assign line     = (state == TX_SHIFT) ? sh[0] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= TX_IDLE;
         cnt   <= '0;
         idx   <= '0;
         sh    <= '1;
      end else begin
         case (state)
            TX_IDLE: begin
               if (wr) begin
                  sh    <= {bit9, din, 1'b0};
                  cnt   <= '0;
                  idx   <= '0;
                  state <= TX_SHIFT;
               end
            end
            TX_SHIFT: begin
               if (bit_end) begin
                  cnt <= '0;
                  if (idx == IDX_LAST) begin
                     state <= TX_STOP;
                  end else begin
                     sh  <= {1'b1, sh[NSH-1:1]};
                     idx <= idx + 1'b1;
                  end
               end else if (tick) begin
                  cnt <= cnt + 1'b1;
               end
            end
            TX_STOP: begin
               if (bit_end) begin
                  cnt   <= '0;
                  state <= TX_IDLE;
               end else if (tick) begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: state <= TX_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/uart9_rx.sv
module uart9_rx
   import uart9_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit MAJORITY    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              pin,
   input  logic              enable,
   output logic              frm_valid,
   output logic [DATA_W-1:0] frm_data,
   output logic              frm_bit9
);
   localparam int CW = $clog2(OVS);
   localparam int RW = $clog2(DATA_W + 1);
   localparam logic [CW-1:0] CNT_LAST = CW'(OVS - 1);
   localparam logic [CW-1:0] CNT_MID  = CW'(OVS / 2);
   localparam logic [CW-1:0] CNT_PRE  = CW'(OVS / 2 - 1);
   localparam logic [CW-1:0] CNT_POST = CW'(OVS / 2 + 1);
   localparam logic [RW-1:0] IDX_LAST = RW'(DATA_W);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   line;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
   end
   assign line = sync_q[SYNC_STAGES-1];

   rx_state_e       state;
   logic [CW-1:0]   cnt;
   logic [RW-1:0]   idx;
   logic [DATA_W:0] sh;
   logic [2:0]      votes;
   logic            armed;
   logic            bit_val;

   generate
      if (MAJORITY) begin : g_vote
         assign bit_val = vote3(votes);
      end else begin : g_centre
         logic unused_side;
         assign unused_side = votes[0] ^ votes[2];
         assign bit_val     = votes[1];
      end
   endgenerate

   assign frm_data = sh[DATA_W-1:0];
   assign frm_bit9 = sh[DATA_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= RX_IDLE;
         cnt       <= '0;
         idx       <= '0;
         sh        <= '0;
         votes     <= '0;
         armed     <= 1'b0;
         frm_valid <= 1'b0;
      end else begin
         frm_valid <= 1'b0;
         case (state)
            RX_IDLE: begin
               if (tick) begin
                  armed <= line;
                  if (enable && armed && !line) begin
                     cnt   <= '0;
                     state <= RX_START;
                  end
               end
            end
            RX_START: begin
               if (tick) begin
                  if ((cnt == CNT_MID) && line) begin
                     armed <= 1'b1;
                     state <= RX_IDLE;
                  end else if (cnt == CNT_LAST) begin
                     cnt   <= '0;
                     idx   <= '0;
                     state <= RX_BITS;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            RX_BITS: begin
               if (tick) begin
                  if (cnt == CNT_PRE)  votes[0] <= line;
                  if (cnt == CNT_MID)  votes[1] <= line;
                  if (cnt == CNT_POST) votes[2] <= line;
                  if (cnt == CNT_LAST) begin
                     cnt <= '0;
                     sh  <= {bit_val, sh[DATA_W:1]};
                     if (idx == IDX_LAST) state <= RX_STOP;
                     else                 idx   <= idx + 1'b1;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            RX_STOP: begin
               if (tick) begin
                  if (cnt == CNT_MID) begin
                     frm_valid <= 1'b1;
                     armed     <= 1'b0;
                     state     <= RX_IDLE;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            default: state <= RX_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/uart9_addr_match.sv
module uart9_addr_match #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] rx_byte,
   input  logic [DATA_W-1:0] own,
   input  logic [DATA_W-1:0] mask,
   input  logic [DATA_W-1:0] bcast,
   output logic              hit
);
   logic [DATA_W-1:0] own_ok;
   logic [DATA_W-1:0] bc_ok;

   generate
      for (genvar i = 0; i < DATA_W; i++) begin : g_bit
         assign own_ok[i] = ~mask[i] | (rx_byte[i] ~^ own[i]);
         assign bc_ok[i]  = ~mask[i] | (rx_byte[i] ~^ bcast[i]);
      end
   endgenerate

   assign hit = (&own_ok) | (&bc_ok);

endmodule

// File: rtl/uart9_addr_port.sv
module uart9_addr_port
   import uart9_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit MAJORITY    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_bit9,
   input  logic              tx_write,
   input  logic              tx_done_clr,
   output logic              tx_pin,
   input  logic              rx_pin,
   input  logic              rx_enable,
   input  logic              mp_mode,
   input  logic [DATA_W-1:0] own_addr,
   input  logic [DATA_W-1:0] addr_mask,
   input  logic [DATA_W-1:0] bcast_addr,
   input  logic              rx_done_clr,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_bit9,
   output logic              tx_done,
   output logic              rx_done,
   output logic              irq
);
   generate
      if (OVS < 4) begin : g_bad_ovs
         $error("OVS must be at least 4");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic              tx_set;
   logic              frm_valid;
   logic [DATA_W-1:0] frm_data;
   logic              frm_bit9;
   logic              addr_hit;
   logic              load;

   uart9_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (baud_tick),
      .wr       (tx_write),
      .din      (tx_data),
      .bit9     (tx_bit9),
      .line     (tx_pin),
      .done_set (tx_set)
   );

   uart9_rx #(
      .DATA_W(DATA_W), .OVS(OVS), .SYNC_STAGES(SYNC_STAGES), .MAJORITY(MAJORITY)
   ) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (baud_tick),
      .pin       (rx_pin),
      .enable    (rx_enable),
      .frm_valid (frm_valid),
      .frm_data  (frm_data),
      .frm_bit9  (frm_bit9)
   );

   uart9_addr_match #(.DATA_W(DATA_W)) u_match (
      .rx_byte (frm_data),
      .own     (own_addr),
      .mask    (addr_mask),
      .bcast   (bcast_addr),
      .hit     (addr_hit)
   );

   assign load = frm_valid && !rx_done && (!mp_mode || (frm_bit9 && addr_hit));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_done <= 1'b0;
         rx_done <= 1'b0;
         rx_data <= '0;
         rx_bit9 <= 1'b0;
      end else begin
         if (tx_set)           tx_done <= 1'b1;
         else if (tx_done_clr) tx_done <= 1'b0;
         if (load) begin
            rx_done <= 1'b1;
            rx_data <= frm_data;
            rx_bit9 <= frm_bit9;
         end else if (rx_done_clr) begin
            rx_done <= 1'b0;
         end
      end
   end

   assign irq = tx_done | rx_done;

endmodule

// File: rtl/uart9_addr_port_chk.sv
module uart9_addr_port_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tx_pin,
   input logic              tx_done,
   input logic              tx_done_clr,
   input logic              rx_done,
   input logic              rx_done_clr,
   input logic              mp_mode,
   input logic [DATA_W-1:0] rx_data,
   input logic              rx_bit9
);
   a_r2_done_in_stop: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_done) |-> tx_pin);

   a_r2_tx_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_done && !tx_done_clr) |=> tx_done);

   a_r6_rx_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && !rx_done_clr) |=> (rx_done && $stable(rx_data) && $stable(rx_bit9)));

   a_r6_rx_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && rx_done_clr) |=> !rx_done);

   a_r7_mp_needs_bit9: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(rx_done) && $past(mp_mode)) |-> rx_bit9);

   a_r8_buffer_only_on_load: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable({rx_data, rx_bit9})) |-> $rose(rx_done));

endmodule

bind uart9_addr_port uart9_addr_port_chk #(.DATA_W(DATA_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tx_pin      (tx_pin),
   .tx_done     (tx_done),
   .tx_done_clr (tx_done_clr),
   .rx_done     (rx_done),
   .rx_done_clr (rx_done_clr),
   .mp_mode     (mp_mode),
   .rx_data     (rx_data),
   .rx_bit9     (rx_bit9)
);

// File: tb/uart9_addr_port_test.sv
module uart9_addr_port_test;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       baud_tick;
   logic [7:0] tx_data;
   logic       tx_bit9;
   logic       tx_write;
   logic       tx_done_clr;
   logic       tx_pin;
   logic       rx_pin;
   logic       rx_enable;
   logic       mp_mode;
   logic [7:0] own_addr;
   logic [7:0] addr_mask;
   logic [7:0] bcast_addr;
   logic       rx_done_clr;
   logic [7:0] rx_data;
   logic       rx_bit9;
   logic       tx_done;
   logic       rx_done;
   logic       irq;

   int total = 0;
   int bad   = 0;
   int div   = 1;
   int tcnt  = 0;
   logic [7:0] last_data = 8'h00;
   logic       last_b9   = 1'b0;

   always #2 clk = ~clk;

   uart9_addr_port uut (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
      .tx_data(tx_data), .tx_bit9(tx_bit9), .tx_write(tx_write),
      .tx_done_clr(tx_done_clr), .tx_pin(tx_pin), .rx_pin(rx_pin),
      .rx_enable(rx_enable), .mp_mode(mp_mode), .own_addr(own_addr),
      .addr_mask(addr_mask), .bcast_addr(bcast_addr),
      .rx_done_clr(rx_done_clr), .rx_data(rx_data), .rx_bit9(rx_bit9),
      .tx_done(tx_done), .rx_done(rx_done), .irq(irq)
   );

   always @(negedge clk) begin
      tcnt      = (tcnt + 1 >= div) ? 0 : tcnt + 1;
      baud_tick = (tcnt == 0);
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send_rx(input logic [7:0] b, input logic b9, input logic stopv,
                          input logic glitch);
      logic [10:0] bits;
      bits = {stopv, b9, b, 1'b0};
      for (int j = 0; j < 11; j++) begin
         for (int k = 0; k < 16 * div; k++) begin
            rx_pin = (glitch && j >= 1 && j <= 9 && k == 9) ? ~bits[j] : bits[j];
            @(negedge clk);
         end
      end
      rx_pin = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic clear_rx();
      rx_done_clr = 1'b1;
      @(negedge clk);
      rx_done_clr = 1'b0;
      @(negedge clk);
   endtask

   task automatic rx_case(input string req, input logic [7:0] b, input logic b9,
                          input logic stopv, input logic glitch, input logic exp_load);
      send_rx(b, b9, stopv, glitch);
      chk({req, " rx_done"}, rx_done, exp_load);
      if (exp_load) begin
         last_data = b;
         last_b9   = b9;
      end
      chk({req, " rx_data"}, rx_data, last_data);
      chk({req, " rx_bit9"}, rx_bit9, last_b9);
      if (exp_load) begin
         chk("R11 irq with rx_done", irq, 1'b1);
         clear_rx();
         chk("R6 rx_done cleared", rx_done, 1'b0);
      end
   endtask

   task automatic tx_case(input logic [7:0] d, input logic b9, input logic disturb);
      logic [10:0] bits;
      bits = {1'b1, b9, d, 1'b0};
      tx_data  = d;
      tx_bit9  = b9;
      tx_write = 1'b1;
      @(negedge clk);
      tx_write = 1'b0;
      tx_data  = ~d;
      tx_bit9  = ~b9;
      repeat (8) @(negedge clk);
      for (int j = 0; j < 10; j++) begin
         chk($sformatf("R1 tx bit %0d", j), tx_pin, bits[j]);
         if (j == 9) chk("R2 tx_done low in ninth bit", tx_done, 1'b0);
         if (j == 9) break;
         if (disturb && j == 3) begin
            tx_write = 1'b1;
            @(negedge clk);
            tx_write = 1'b0;
            repeat (15) @(negedge clk);
         end else begin
            repeat (16) @(negedge clk);
         end
      end
      repeat (7) @(negedge clk);
      chk("R2 tx_done low before stop", tx_done, 1'b0);
      @(negedge clk);
      chk("R2 tx_done at stop start", tx_done, 1'b1);
      chk("R1 stop bit high", tx_pin, 1'b1);
      chk("R11 irq with tx_done", irq, 1'b1);
      repeat (20) @(negedge clk);
      chk("R2 tx_done held", tx_done, 1'b1);
      chk("R1 idle high", tx_pin, 1'b1);
      tx_done_clr = 1'b1;
      @(negedge clk);
      tx_done_clr = 1'b0;
      @(negedge clk);
      chk("R2 tx_done cleared", tx_done, 1'b0);
      chk("R11 irq low", irq, 1'b0);
      if (disturb) chk("R3 no second frame", tx_pin, 1'b1);
   endtask

   initial begin
      repeat (200000) @(negedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; tx_data = 8'h00; tx_bit9 = 1'b0; tx_write = 1'b0;
      tx_done_clr = 1'b0; rx_pin = 1'b1; rx_enable = 1'b0; mp_mode = 1'b0;
      own_addr = 8'h00; addr_mask = 8'h00; bcast_addr = 8'h00; rx_done_clr = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R12 tx_pin", tx_pin, 1'b1);
      chk("R12 tx_done", tx_done, 1'b0);
      chk("R12 rx_done", rx_done, 1'b0);
      chk("R12 rx_data", rx_data, 8'h00);
      chk("R12 rx_bit9", rx_bit9, 1'b0);
      chk("R12 irq", irq, 1'b0);

      tx_case(8'h00, 1'b1, 1'b0);
      tx_case(8'hFF, 1'b0, 1'b0);
      tx_case(8'hA5, 1'b1, 1'b1);
      tx_case(8'h3C, 1'b0, 1'b0);

      // R5: disabled receiver
      repeat (20) @(negedge clk);
      rx_case("R5 disabled", 8'h11, 1'b1, 1'b1, 1'b0, 1'b0);

      rx_enable = 1'b1;
      repeat (20) @(negedge clk);
      // R4: plain reception, stop level varied
      for (int i = 0; i < 40; i++) begin
         rx_case("R4 plain", 8'((i * 37 + 11) & 255), i[0], (i % 5) != 0, 1'b0, 1'b1);
      end
      // R10: centre glitches on every data bit
      rx_case("R10 glitch", 8'h96, 1'b1, 1'b1, 1'b1, 1'b1);
      rx_case("R10 glitch", 8'h69, 1'b0, 1'b1, 1'b1, 1'b1);
      // R4: slower tick rate
      div = 3;
      repeat (10) @(negedge clk);
      rx_case("R4 slow tick", 8'h5C, 1'b1, 1'b1, 1'b0, 1'b1);
      div = 1;
      repeat (10) @(negedge clk);

      // R6: overrun
      send_rx(8'h21, 1'b1, 1'b1, 1'b0);
      send_rx(8'h42, 1'b0, 1'b1, 1'b0);
      chk("R6 flag kept", rx_done, 1'b1);
      chk("R6 first byte kept", rx_data, 8'h21);
      chk("R6 first bit9 kept", rx_bit9, 1'b1);
      last_data = 8'h21; last_b9 = 1'b1;
      clear_rx();
      chk("R6 cleared", rx_done, 1'b0);

      // R9: false start then a good frame
      rx_pin = 1'b0;
      repeat (5) @(negedge clk);
      rx_pin = 1'b1;
      repeat (40) @(negedge clk);
      chk("R9 no frame", rx_done, 1'b0);
      rx_case("R9 after false start", 8'h7E, 1'b0, 1'b1, 1'b0, 1'b1);

      // R7/R8: address sweep in multidrop mode
      mp_mode = 1'b1; own_addr = 8'hA5; addr_mask = 8'hF3; bcast_addr = 8'hFF;
      for (int b = 0; b < 256; b++) begin
         logic [7:0] bv;
         logic       hit;
         bv  = 8'(b);
         hit = (((bv ^ own_addr) & addr_mask) == 8'h00) ||
               (((bv ^ bcast_addr) & addr_mask) == 8'h00);
         rx_case(hit ? "R7 address hit" : "R8 address miss", bv, 1'b1, 1'b1, 1'b0, hit);
      end
      rx_case("R7 own match bit9 zero", 8'hA5, 1'b0, 1'b1, 1'b0, 1'b0);
      rx_case("R7 bcast match bit9 zero", 8'hFF, 1'b0, 1'b1, 1'b0, 1'b0);
      addr_mask = 8'h00;
      rx_case("R7 empty mask", 8'h0F, 1'b1, 1'b1, 1'b0, 1'b1);
      rx_case("R8 empty mask bit9 zero", 8'hF0, 1'b0, 1'b1, 1'b0, 1'b0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule